// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address of up to 52 bits. It does this by reading a four-level radix translation table held in memory. A walk begins at a root table whose physical base comes in on a dedicated input. Each level is one 8-byte entry read through a simple request/response read port. Each read uses a 9-bit slice of the virtual address as the index into the current 512-entry table.

A walk normally takes four reads and ends on a 4 KB frame. If the entry read at the third level is marked as a large mapping, the walk stops after three reads and ends on a 2 MB frame. An entry with its present bit clear ends the walk at once with a fault, and the fault reports the level where it happened.

The block handles one walk at a time. A one-cycle start pulse begins a walk. A one-cycle done pulse returns the physical address, a large-page flag and a fault indication.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are low.
- R2: A `start` pulse is accepted only while `busy` is low. `busy` is high from the cycle after acceptance up to the cycle in which `done` pulses, and it is low in that cycle. A `start` seen while `busy` is high has no effect on the walk in progress or on its result.
- R3: Read addresses are table base plus index times 8. The first base is `root_base` with bits [11:0] treated as zero. The indexes are, in order, VA[47:39], VA[38:30], VA[29:21] and VA[20:12]. Each later base is the previous entry's bits [51:12] followed by twelve zero bits.
- R4: Bit 0 of an entry is the present flag. If a read entry has bit 0 equal to 0, the walk ends with `fault`=1 and `fault_lvl` set to the level of that read (0 = first read, 3 = fourth read). In that case `paddr` is 0 and `big_page` is 0, and no further read is issued.
- R5: If the third entry is present and has bit 7 set, the walk ends after exactly 3 reads. It returns `big_page`=1 and `paddr` = {entry[51:21], VA[20:0]}.
- R6: Bit 7 has no effect in the first, second and fourth entries.
- R7: A walk with no fault and no large mapping ends after exactly 4 reads. It returns `big_page`=0 and `paddr` = {fourth entry[51:12], VA[11:0]}.
- R8: Each read is a one-cycle `mem_req` pulse. The next read is issued only after `mem_rvalid` has returned the previous entry. A `mem_rvalid` that arrives when no read is outstanding is ignored.
- R9: `done` is a one-cycle pulse. `paddr`, `big_page`, `fault` and `fault_lvl` change only in the cycle `done` rises and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 52 | Physical base of the top-level table (low 12 bits ignored) |
| start | input | 1 | One-cycle pulse that starts a walk |
| vaddr | input | 48 | Virtual address, sampled with `start` |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 52 | Physical address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 52 | Translated physical address |
| big_page | output | 1 | Result maps a 2 MB page |
| fault | output | 1 | Walk hit a non-present entry |
| fault_lvl | output | 2 | Level of the faulting read |

## Verification
The bench builds the walker with its default widths: a 48-bit virtual address, a 52-bit physical address, 9-bit indexes, four levels and 64-bit entries. These are the only values for which the level count, the large-page cut at the third level and the 21-bit large offset all line up. With these values the bench reaches every table level as a fault point. It also reaches both completion lengths and the all-ones and all-zeros index extremes. Random tables put junk in the unused entry bits and set bit 7 at non-deciding levels, which exposes any field taken from the wrong position.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pt_walk_addr.sv
// Forms the physical address of the entry read at the current level.
module pt_walk_addr #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int LVLS  = 4,
  localparam int LVL_W = $clog2(LVLS)
) (
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  base,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int ENT_SH = 3;

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] b,
                                                input logic [IDX_W-1:0] ix);
    return b + {{(PA_W-IDX_W-ENT_SH){1'b0}}, ix, {ENT_SH{1'b0}}};
  endfunction

  logic [IDX_W-1:0] idx [LVLS];

  for (genvar g = 0; g < LVLS; g++) begin : g_idx
    assign idx[g] = va[VA_W-1-g*IDX_W -: IDX_W];
  end

  logic unused_off;
  assign unused_off = ^va[OFF_W-1:0];

  assign entry_addr = slot_addr(base, idx[lvl]);
endmodule

// File: rtl/pt_walk_decode.sv
// Interprets a returned entry at the current level.
module pt_walk_decode #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int LVLS  = 4,
  parameter int PTE_W = 64,
  localparam int LVL_W  = $clog2(LVLS),
  localparam int BIG_W  = OFF_W + IDX_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  output logic             present,
  output logic             is_big,
  output logic             is_last,
  output logic [PA_W-1:0]  next_base,
  output logic [PA_W-1:0]  pa_small,
  output logic [PA_W-1:0]  pa_big
);
  localparam int PS_BIT = 7;
  localparam logic [LVL_W-1:0] BIG_LVL  = LVL_W'(LVLS - 2);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LVLS - 1);

  function automatic logic [PA_W-1:0] frame_of(input logic [PTE_W-1:0] e);
    return {e[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] join_small(input logic [PTE_W-1:0] e,
                                                 input logic [VA_W-1:0] v);
    return {e[PA_W-1:OFF_W], v[OFF_W-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] join_big(input logic [PTE_W-1:0] e,
                                               input logic [VA_W-1:0] v);
    return {e[PA_W-1:BIG_W], v[BIG_W-1:0]};
  endfunction

  assign present   = pte[0];
  assign is_big    = (lvl == BIG_LVL) && pte[PS_BIT];
  assign is_last   = (lvl == LAST_LVL);
  assign next_base = frame_of(pte);
  assign pa_small  = join_small(pte, va);
  assign pa_big    = join_big(pte, va);

  logic unused_bits;
  assign unused_bits = ^{pte[PTE_W-1:PA_W], pte[OFF_W-1:PS_BIT+1], pte[PS_BIT-1:1]};
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencing, per-walk state and result registers.
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int OFF_W = 12,
  parameter int LVLS  = 4,
  localparam int LVL_W = $clog2(LVLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  root_base,
  input  logic             mem_rvalid,
  input  logic             present,
  input  logic             is_big,
  input  logic             is_last,
  input  logic [PA_W-1:0]  next_base,
  input  logic [PA_W-1:0]  pa_small,
  input  logic [PA_W-1:0]  pa_big,
  output logic [VA_W-1:0]  va_q,
  output logic [PA_W-1:0]  base_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             walk_accept,
  output logic             resp_take,
  output logic             busy,
  output logic             mem_req,
  output logic             done,
  output logic [PA_W-1:0]  paddr,
  output logic             big_page,
  output logic             fault,
  output logic [LVL_W-1:0] fault_lvl
);
  walk_st_e st;

  assign walk_accept = (st == ST_IDLE) && start;
  assign resp_take   = (st == ST_WAIT) && mem_rvalid;
  assign busy        = (st != ST_IDLE);
  assign mem_req     = (st == ST_ISSUE);

  logic unused_root;
  assign unused_root = ^root_base[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      lvl_q     <= '0;
      done      <= 1'b0;
      paddr     <= '0;
      big_page  <= 1'b0;
      fault     <= 1'b0;
      fault_lvl <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (walk_accept) begin
            va_q   <= vaddr;
            base_q <= {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
            lvl_q  <= '0;
            st     <= ST_ISSUE;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (resp_take) begin
            if (!present) begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              fault     <= 1'b1;
              fault_lvl <= lvl_q;
              paddr     <= '0;
              big_page  <= 1'b0;
            end else if (is_big) begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              fault     <= 1'b0;
              fault_lvl <= '0;
              paddr     <= pa_big;
              big_page  <= 1'b1;
            end else if (is_last) begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              fault     <= 1'b0;
              fault_lvl <= '0;
              paddr     <= pa_small;
              big_page  <= 1'b0;
            end else begin
              base_q <= next_base;
              lvl_q  <= lvl_q + 1'b1;
              st     <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int LVLS  = 4,
  parameter int PTE_W = 64,
  localparam int LVL_W = $clog2(LVLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  root_base,
  input  logic             start,
  input  logic [VA_W-1:0]  vaddr,
  output logic             busy,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             done,
  output logic [PA_W-1:0]  paddr,
  output logic             big_page,
  output logic             fault,
  output logic [LVL_W-1:0] fault_lvl
);
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             walk_accept;
  logic             resp_take;
  logic             present;
  logic             is_big;
  logic             is_last;
  logic [PA_W-1:0]  next_base;
  logic [PA_W-1:0]  pa_small;
  logic [PA_W-1:0]  pa_big;

  pt_walk_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVLS(LVLS)
  ) u_addr (
    .va         (va_q),
    .base       (base_q),
    .lvl        (lvl_q),
    .entry_addr (mem_addr)
  );

  pt_walk_decode #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .LVLS(LVLS), .PTE_W(PTE_W)
  ) u_dec (
    .pte       (mem_rdata),
    .lvl       (lvl_q),
    .va        (va_q),
    .present   (present),
    .is_big    (is_big),
    .is_last   (is_last),
    .next_base (next_base),
    .pa_small  (pa_small),
    .pa_big    (pa_big)
  );

  pt_walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .LVLS(LVLS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .vaddr       (vaddr),
    .root_base   (root_base),
    .mem_rvalid  (mem_rvalid),
    .present     (present),
    .is_big      (is_big),
    .is_last     (is_last),
    .next_base   (next_base),
    .pa_small    (pa_small),
    .pa_big      (pa_big),
    .va_q        (va_q),
    .base_q      (base_q),
    .lvl_q       (lvl_q),
    .walk_accept (walk_accept),
    .resp_take   (resp_take),
    .busy        (busy),
    .mem_req     (mem_req),
    .done        (done),
    .paddr       (paddr),
    .big_page    (big_page),
    .fault       (fault),
    .fault_lvl   (fault_lvl)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 52,
  parameter int LVLS = 4,
  localparam int LVL_W = $clog2(LVLS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             mem_req,
  input logic             done,
  input logic             fault,
  input logic             big_page,
  input logic [PA_W-1:0]  paddr,
  input logic [LVL_W-1:0] fault_lvl
);
  logic [3:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               rd_cnt <= '0;
    else if (start && !busy)  rd_cnt <= '0;
    else if (mem_req)         rd_cnt <= rd_cnt + 1'b1;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);                                                  // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);                                                    // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                        // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                        // R2
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (!big_page && paddr == '0));                        // R4
  AST_FAULT_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (rd_cnt == 4'(fault_lvl) + 4'd1));                  // R4
  AST_BIG_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && big_page) |-> (rd_cnt == 4'(LVLS - 1)));                       // R5
  AST_SMALL_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && !big_page) |-> (rd_cnt == 4'(LVLS)));                // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> ($stable(paddr) && $stable(big_page) && $stable(fault))); // R9
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .LVLS(LVLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .mem_req   (mem_req),
  .done      (done),
  .fault     (fault),
  .big_page  (big_page),
  .paddr     (paddr),
  .fault_lvl (fault_lvl)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root_base = '0;
  logic        start = 1'b0;
  logic [47:0] vaddr = '0;
  logic        busy, mem_req, done, big_page, fault;
  logic [51:0] mem_addr, paddr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [1:0]  fault_lvl;

  int total = 0;
  int bad = 0;
  int reads = 0;
  logic [63:0] mem [logic [51:0]];
  logic        pend = 1'b0;
  int          lat = 0;
  logic [51:0] pend_addr = '0;
  logic        spur = 1'b0;

  always #2 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .start(start), .vaddr(vaddr),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .big_page(big_page),
    .fault(fault), .fault_lvl(fault_lvl)
  );

  // Memory responder: 1..3 cycle latency, unknown addresses read as zero.
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (spur) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= 64'hFFFF_FFFF_FFFF_FFFF;
    end
    if (mem_req) begin
      pend      <= 1'b1;
      lat       <= 1 + int'($urandom % 3);
      pend_addr <= mem_addr;
      reads     <= reads + 1;
    end else if (pend) begin
      if (lat <= 1) begin
        pend       <= 1'b0;
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [51:0] slot(input logic [51:0] b, input logic [47:0] v, input int l);
    logic [8:0] ix;
    ix = v[47 - 9*l -: 9];
    return {b[51:12], 12'h000} + {40'h0, ix, 3'b000};
  endfunction

  function automatic logic [51:0] exp_small(input logic [39:0] fr, input logic [47:0] v);
    return {fr, v[11:0]};
  endfunction

  function automatic logic [51:0] exp_big(input logic [30:0] fr, input logic [47:0] v);
    return {fr, v[20:0]};
  endfunction

  // kind: 0 = 4 KB mapping, 1 = 2 MB mapping, 2 = fault at level flvl
  task automatic walk(input logic [47:0] va, input logic [51:0] root, input int kind,
                      input int flvl, input bit ps_junk, input bit poke_busy);
    logic [51:0] b;
    logic [51:0] exp_pa;
    logic [63:0] e;
    logic [39:0] fr;
    logic [30:0] fb;
    int exp_reads;
    int r0;
    int wd;
    mem.delete();
    b = root;
    exp_pa = '0;
    exp_reads = 0;
    for (int l = 0; l < 4; l++) begin
      e = {$urandom, $urandom};
      exp_reads = l + 1;
      if (kind == 2 && l == flvl) begin
        e[0] = 1'b0;
        mem[slot(b, va, l)] = e;
        break;
      end
      e[0] = 1'b1;
      if (kind == 1 && l == 2) begin
        fb = 31'($urandom);
        e[51:21] = fb;
        e[7] = 1'b1;
        mem[slot(b, va, l)] = e;
        exp_pa = exp_big(fb, va);
        break;
      end
      fr = {8'($urandom), $urandom};
      e[51:12] = fr;
      e[7] = (l == 2) ? 1'b0 : (ps_junk ? 1'b1 : e[7]);
      mem[slot(b, va, l)] = e;
      b = {fr, 12'h000};
      if (l == 3) exp_pa = exp_small(fr, va);
    end

    @(negedge clk);
    r0 = reads;
    vaddr = va;
    root_base = root;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vaddr = ~va;
    root_base = ~root;
    chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'h1);
    if (poke_busy) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 300) begin
      @(negedge clk);
      wd++;
    end
    chk(wd < 300, "R9", "walk completes", 64'(wd), 64'h0);
    chk(busy == 1'b0, "R2", "busy low at done", 64'(busy), 64'h0);
    chk(fault == (kind == 2), "R4", "fault flag", 64'(fault), 64'(kind == 2));
    if (kind == 2)
      chk(fault_lvl == 2'(flvl), "R4", "fault level", 64'(fault_lvl), 64'(flvl));
    chk(big_page == (kind == 1), kind == 1 ? "R5" : "R7", "big_page",
        64'(big_page), 64'(kind == 1));
    chk(paddr == exp_pa, kind == 1 ? "R5" : (ps_junk ? "R6" : "R7"), "paddr",
        64'(paddr), 64'(exp_pa));
    chk((reads - r0) == exp_reads, kind == 0 ? "R3" : "R8", "read count",
        64'(reads - r0), 64'(exp_reads));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done is one pulse", 64'(done), 64'h0);
    chk(paddr == exp_pa, "R9", "paddr held", 64'(paddr), 64'(exp_pa));
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'h0);
    chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'h0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'h0);

    // Directed: index extremes and root low bits (R3)
    walk(48'h0, 52'h0_0000_0010_0FFF, 0, 0, 1'b0, 1'b0);
    walk(48'hFFFF_FFFF_FFFF, 52'hF_FFFF_FF00_0ABC, 0, 0, 1'b0, 1'b0);
    // 2 MB mappings (R5)
    walk(48'hFFFF_FFFF_FFFF, 52'h1_2345_6789_A000, 1, 0, 1'b0, 1'b0);
    walk(48'h0000_001F_FFFF, 52'h0_0000_0000_1000, 1, 0, 1'b1, 1'b0);
    // Bit 7 set at non-deciding levels (R6)
    walk(48'h7A5C_3E91_0BCD, 52'h0_ABCD_E000_0000, 0, 0, 1'b1, 1'b0);
    // Faults at each level (R4)
    for (int l = 0; l < 4; l++)
      walk({$urandom, $urandom}, {$urandom, $urandom}, 2, l, 1'b0, 1'b0);
    // Start while busy is ignored (R2)
    walk(48'h1234_5678_9ABC, 52'h0_0000_4444_5000, 0, 0, 1'b0, 1'b1);
    walk(48'h8000_0020_0000, 52'h0_0000_4444_5000, 1, 0, 1'b0, 1'b1);
    // Stray response while idle is ignored (R8)
    @(negedge clk);
    spur = 1'b1;
    @(negedge clk);
    spur = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", "stray rvalid while idle",
        64'({done, busy}), 64'h0);
    walk(48'h0F0F_F0F0_1234, 52'h0_0000_9999_0000, 0, 0, 1'b0, 1'b0);

    // Random walks
    for (int i = 0; i < 60; i++) begin
      int k;
      k = int'($urandom % 3);
      walk({$urandom, $urandom}, {$urandom, $urandom}, k, int'($urandom % 4),
           1'($urandom), (i % 7) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule